// File: doc/BRIEF.md
# Fixed-Point Delayed LMS Adaptive FIR Filter

This block is an N-tap adaptive FIR filter built on the delayed least-mean-square update rule, in two's complement fixed-point arithmetic. Each accepted sample pair, an input `x` and a desired value `d`, passes through a tap delay line and an inner product against the filter-side weights. The result is cut to the output word `y`, and the error `e = d - y` is formed. The filter returns both `y` and `e` two clock cycles after the sample is accepted.

The weight-update side runs one iteration per accepted sample, but it does not use the newest error. It draws on an error that is `ERR_DLY` samples old, together with the tap vector that belonged to that same sample. The filter side does not use the newest weights either: it reads a copy that is `WGT_DLY` samples old. The step size is a power of two, so scaling by it is only a right shift folded into one truncation of the product `e*x`. That truncation has no rounding and no overflow guard. A per-sample adapt flag freezes the weights while filtering carries on. Every delay counts accepted samples, not clock cycles, so idle cycles between samples do not change any result.

Top module: `dlms_filter`

## Requirements
- R1: Reset clears the weights, the tap line, the error/tap delay queue and the filter-weight history to zero, and drives `out_valid`, `out_y` and `out_e` to 0. As a result, the first `ERR_DLY+WGT_DLY+1` samples after reset give `y = 0`.
- R2: `out_valid` is high in the cycle exactly two rising edges after a cycle with `in_valid` high. Each accepted sample produces exactly one output.
- R3: For sample n, y(n) = floor( sum over k of x(n-k)*wf_k / 2^(X_W+log2 N_TAPS) ), kept to W_W bits, where tap k = 0 is the newest sample. This keeps the top W_W bits of the X_W+W_W+log2 N_TAPS bit sum.
- R4: e(n) = d(n) - y(n), taken modulo 2^W_W, with no saturation.
- R5: Each weight increment is bits [W_W-1:0] of the product e*x arithmetic-shifted right by X_W - 2*X_I - log2 N_TAPS + MU_SHIFT. The lower bits are dropped without rounding. The weight addition wraps modulo 2^W_W.
- R6: The update at sample n uses the error e(n-ERR_DLY) and the tap vector of that same earlier sample. ERR_DLY is at least 1.
- R7: The filter weights used for sample n equal the adapted weights as they stood before sample n-WGT_DLY was processed. WGT_DLY = 0 means the current weights are used.
- R8: When `in_adapt` is low for a sample, no weight changes at that sample. `y` and `e` are still produced.
- R9: Cycles with `in_valid` low do not advance the taps, the queues or the weights, and `out_y`/`out_e` hold their last values while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_x`, `in_d`, `in_adapt` this cycle |
| in_adapt | input | 1 | Allow weight update for this sample |
| in_x | input | X_W | Input sample, X_I integer bits |
| in_d | input | W_W | Desired sample, same format as `y` |
| out_valid | output | 1 | `out_y`/`out_e` carry a new result |
| out_y | output | W_W | Filter output |
| out_e | output | W_W | Error d - y |

## Verification
The bench builds the filter with 4 taps and 8-bit input and weight words (X_I = 2, MU_SHIFT = 4, so the increment shift is 6), with ERR_DLY = 2 and WGT_DLY = 1. The narrow words let one adapting run feed every one of the 65,536 (x, d) byte pairs, and they make weight wrap-around and increment truncation happen often rather than rarely. An integer model in the bench checks each output against its own computation. Nonzero delays on both the error side and the weight side show whether each history is indexed correctly. Idle gaps, frozen and alternating adapt runs, and a reset in the middle of the run cover the gating and clearing rules.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

   // Right shift that turns e*x into a weight-format increment
   function automatic int incr_shift(int x_w, int x_i, int log_n, int mu_sh);
      return x_w - 2 * x_i - log_n + mu_sh;
   endfunction

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dlms_tapline.sv
module dlms_tapline #(
   parameter int N_TAPS = 4,
   parameter int X_W    = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    shift_en,
   input  logic [X_W-1:0]          x_in,
   output logic [N_TAPS*X_W-1:0]   taps
);
   logic [X_W-1:0] line [N_TAPS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < N_TAPS; k++) line[k] <= '0;
      end else if (shift_en) begin
         line[0] <= x_in;
         for (int k = 1; k < N_TAPS; k++) line[k] <= line[k-1];
      end
   end

   for (genvar k = 0; k < N_TAPS; k++) begin : g_pack
      assign taps[k*X_W +: X_W] = line[k];
   end
endmodule

// File: rtl/dlms_errcalc.sv
module dlms_errcalc #(
   parameter int N_TAPS = 4,
   parameter int X_W    = 16,
   parameter int W_W    = 16,
   parameter int LOG_N  = 2
) (
   input  logic [N_TAPS*X_W-1:0] taps,
   input  logic [N_TAPS*W_W-1:0] wts,
   input  logic [W_W-1:0]        d,
   output logic [W_W-1:0]        y,
   output logic [W_W-1:0]        e
);
   localparam int P_W = X_W + W_W;
   localparam int S_W = P_W + LOG_N;
   localparam int DROP = X_W + LOG_N;

   logic signed [P_W-1:0] prod [N_TAPS];
   logic signed [S_W-1:0] acc;
   logic                  unused_lo;

   for (genvar k = 0; k < N_TAPS; k++) begin : g_mul
      logic [X_W-1:0] xv;
      logic [W_W-1:0] wv;
      assign xv = taps[k*X_W +: X_W];
      assign wv = wts[k*W_W +: W_W];
      assign prod[k] = $signed({{W_W{xv[X_W-1]}}, xv}) *
                       $signed({{X_W{wv[W_W-1]}}, wv});
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < N_TAPS; k++)
         acc = acc + $signed({{LOG_N{prod[k][P_W-1]}}, prod[k]});
   end

   // keep the top W_W bits of the full-precision sum
   assign y         = acc[DROP +: W_W];
   assign unused_lo = ^acc[DROP-1:0];
   assign e         = d - y;
endmodule

// File: rtl/dlms_wupdate.sv
module dlms_wupdate #(
   parameter int N_TAPS  = 4,
   parameter int X_W     = 16,
   parameter int W_W     = 16,
   parameter int INC_SH  = 14,
   parameter int ERR_DLY = 2,
   parameter int WGT_DLY = 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   evt,
   input  logic                   adapt,
   input  logic [W_W-1:0]         e_new,
   input  logic [N_TAPS*X_W-1:0]  taps,
   output logic [N_TAPS*W_W-1:0]  w_master,
   output logic [N_TAPS*W_W-1:0]  w_filt
);
   localparam int P_W = X_W + W_W;

   logic [W_W-1:0]        eq [ERR_DLY];
   logic [N_TAPS*X_W-1:0] xq [ERR_DLY];
   logic [W_W-1:0]        e_old;
   logic [N_TAPS*X_W-1:0] x_old;
   logic [W_W-1:0]        wt  [N_TAPS];
   logic [W_W-1:0]        inc [N_TAPS];

   // error and matching tap vector, ERR_DLY samples deep
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < ERR_DLY; j++) begin
            eq[j] <= '0;
            xq[j] <= '0;
         end
      end else if (evt) begin
         eq[0] <= e_new;
         xq[0] <= taps;
         for (int j = 1; j < ERR_DLY; j++) begin
            eq[j] <= eq[j-1];
            xq[j] <= xq[j-1];
         end
      end
   end

   assign e_old = eq[ERR_DLY-1];
   assign x_old = xq[ERR_DLY-1];

   for (genvar k = 0; k < N_TAPS; k++) begin : g_inc
      logic [X_W-1:0]        xv;
      logic signed [P_W-1:0] pr;
      logic signed [P_W-1:0] sh;
      logic                  unused_hi;
      assign xv = x_old[k*X_W +: X_W];
      assign pr = $signed({{X_W{e_old[W_W-1]}}, e_old}) *
                  $signed({{W_W{xv[X_W-1]}}, xv});
      assign sh = pr >>> INC_SH;
      assign inc[k]    = sh[W_W-1:0];
      assign unused_hi = ^sh[P_W-1:W_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < N_TAPS; k++) wt[k] <= '0;
      end else if (evt && adapt) begin
         for (int k = 0; k < N_TAPS; k++) wt[k] <= wt[k] + inc[k];
      end
   end

   for (genvar k = 0; k < N_TAPS; k++) begin : g_wpack
      assign w_master[k*W_W +: W_W] = wt[k];
   end

   if (WGT_DLY == 0) begin : g_wf_direct
      assign w_filt = w_master;
   end else begin : g_wf_hist
      logic [N_TAPS*W_W-1:0] hist [WGT_DLY];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int j = 0; j < WGT_DLY; j++) hist[j] <= '0;
         end else if (evt) begin
            hist[0] <= w_master;
            for (int j = 1; j < WGT_DLY; j++) hist[j] <= hist[j-1];
         end
      end
      assign w_filt = hist[WGT_DLY-1];
   end
endmodule

// File: rtl/dlms_filter.sv
module dlms_filter #(
   parameter int N_TAPS   = 4,
   parameter int X_W      = 16,
   parameter int X_I      = 2,
   parameter int W_W      = 16,
   parameter int MU_SHIFT = X_I + $clog2(N_TAPS),
   parameter int ERR_DLY  = 2,
   parameter int WGT_DLY  = 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic           in_adapt,
   input  logic [X_W-1:0] in_x,
   input  logic [W_W-1:0] in_d,
   output logic           out_valid,
   output logic [W_W-1:0] out_y,
   output logic [W_W-1:0] out_e
);
   localparam int LOG_N  = $clog2(N_TAPS);
   localparam int INC_SH = dlms_pkg::incr_shift(X_W, X_I, LOG_N, MU_SHIFT);

   if (!dlms_pkg::is_pow2(N_TAPS) || N_TAPS < 2) begin : g_bad_taps
      $error("N_TAPS must be a power of two, at least 2");
   end
   if (ERR_DLY < 1 || WGT_DLY < 0) begin : g_bad_dly
      $error("ERR_DLY must be >= 1 and WGT_DLY >= 0");
   end
   if (X_I < 0 || X_I >= X_W) begin : g_bad_fmt
      $error("X_I must lie in 0..X_W-1");
   end
   if (INC_SH < 0 || INC_SH >= X_W + W_W) begin : g_bad_shift
      $error("step-size shift out of range for the word formats");
   end

   logic [N_TAPS*X_W-1:0] taps;
   logic [N_TAPS*W_W-1:0] w_master;
   logic [N_TAPS*W_W-1:0] w_filt;
   logic                  s1_v;
   logic                  s1_ad;
   logic [W_W-1:0]        s1_d;
   logic [W_W-1:0]        y_c;
   logic [W_W-1:0]        e_c;

   dlms_tapline #(.N_TAPS(N_TAPS), .X_W(X_W)) u_taps (
      .clk(clk), .rst(rst), .shift_en(in_valid), .x_in(in_x), .taps(taps)
   );

   dlms_errcalc #(.N_TAPS(N_TAPS), .X_W(X_W), .W_W(W_W), .LOG_N(LOG_N)) u_err (
      .taps(taps), .wts(w_filt), .d(s1_d), .y(y_c), .e(e_c)
   );

   dlms_wupdate #(
      .N_TAPS(N_TAPS), .X_W(X_W), .W_W(W_W), .INC_SH(INC_SH),
      .ERR_DLY(ERR_DLY), .WGT_DLY(WGT_DLY)
   ) u_upd (
      .clk(clk), .rst(rst), .evt(s1_v), .adapt(s1_ad), .e_new(e_c),
      .taps(taps), .w_master(w_master), .w_filt(w_filt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_v      <= 1'b0;
         s1_ad     <= 1'b0;
         s1_d      <= '0;
         out_valid <= 1'b0;
         out_y     <= '0;
         out_e     <= '0;
      end else begin
         s1_v      <= in_valid;
         out_valid <= s1_v;
         if (in_valid) begin
            s1_d  <= in_d;
            s1_ad <= in_adapt;
         end
         if (s1_v) begin
            out_y <= y_c;
            out_e <= e_c;
         end
      end
   end
endmodule

// File: rtl/dlms_filter_chk.sv
module dlms_filter_chk #(
   parameter int N_TAPS = 4,
   parameter int W_W    = 16
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  in_valid,
   input logic [W_W-1:0]        in_d,
   input logic                  out_valid,
   input logic [W_W-1:0]        out_y,
   input logic [W_W-1:0]        out_e,
   input logic                  s1_v,
   input logic                  s1_ad,
   input logic [N_TAPS*W_W-1:0] w_master
);
   AST_LATENCY_ON: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid); // R2
   AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 !out_valid); // R2
   AST_ERR_RELATION: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_e == W_W'($past(in_d, 2) - out_y))); // R4
   AST_FROZEN_WEIGHTS: assert property (@(posedge clk) disable iff (rst)
      (s1_v && !s1_ad) |=> $stable(w_master)); // R8
   AST_IDLE_WEIGHTS: assert property (@(posedge clk) disable iff (rst)
      !s1_v |=> $stable(w_master)); // R9
   AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_y) && $stable(out_e))); // R9
endmodule

bind dlms_filter dlms_filter_chk #(.N_TAPS(N_TAPS), .W_W(W_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_d(in_d),
   .out_valid(out_valid), .out_y(out_y), .out_e(out_e),
   .s1_v(s1_v), .s1_ad(s1_ad), .w_master(w_master)
);

// File: tb/tb_dlms_filter.sv
module tb_dlms_filter;
   localparam int NT    = 4;
   localparam int XW    = 8;
   localparam int XI    = 2;
   localparam int WW    = 8;
   localparam int LOGN  = 2;
   localparam int MU    = 4;
   localparam int ED    = 2;
   localparam int WD    = 1;
   localparam int INCSH = XW - 2 * XI - LOGN + MU;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_adapt = 1'b0;
   logic [XW-1:0] in_x = '0;
   logic [WW-1:0] in_d = '0;
   logic          out_valid;
   logic [WW-1:0] out_y;
   logic [WW-1:0] out_e;

   dlms_filter #(
      .N_TAPS(NT), .X_W(XW), .X_I(XI), .W_W(WW),
      .MU_SHIFT(MU), .ERR_DLY(ED), .WGT_DLY(WD)
   ) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_adapt(in_adapt),
      .in_x(in_x), .in_d(in_d), .out_valid(out_valid),
      .out_y(out_y), .out_e(out_e)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // integer reference model, one iteration per accepted sample
   int m_tap [NT];
   int m_w   [NT];
   int m_wr  [8][NT];
   int m_er  [8];
   int m_xr  [8][NT];
   int m_n;

   // expected results in flight: [0] driven last step, [1] visible now
   bit    pv [2];
   int    py [2];
   int    pe [2];
   string pt [2];
   bit    pz [2];
   int    last_y;
   int    last_e;

   function automatic int sxt(int v, int w);
      int m;
      m = v & ((1 << w) - 1);
      return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      m_n = 0;
      for (int k = 0; k < NT; k++) begin
         m_tap[k] = 0;
         m_w[k]   = 0;
         for (int j = 0; j < 8; j++) begin
            m_wr[j][k] = 0;
            m_xr[j][k] = 0;
         end
      end
      for (int j = 0; j < 8; j++) m_er[j] = 0;
      for (int j = 0; j < 2; j++) begin
         pv[j] = 0; py[j] = 0; pe[j] = 0; pt[j] = "R3"; pz[j] = 0;
      end
      last_y = 0;
      last_e = 0;
   endtask

   task automatic model_step(input int x, input int d, input bit ad,
                             output int ye, output int ee);
      int s;
      int eo;
      int ws;
      int wi;
      for (int k = NT - 1; k > 0; k--) m_tap[k] = m_tap[k-1];
      m_tap[0] = sxt(x, XW);
      for (int k = 0; k < NT; k++) m_wr[m_n & 7][k] = m_w[k];
      ws = (m_n - WD) & 7;
      s = 0;
      for (int k = 0; k < NT; k++) s += m_tap[k] * m_wr[ws][k];
      ye = sxt(s >>> (XW + LOGN), WW);
      ee = sxt(sxt(d, WW) - ye, WW);
      wi = (m_n - ED) & 7;
      eo = m_er[wi];
      if (ad) begin
         for (int k = 0; k < NT; k++)
            m_w[k] = sxt(m_w[k] + sxt((eo * m_xr[wi][k]) >>> INCSH, WW), WW);
      end
      m_er[m_n & 7] = ee;
      for (int k = 0; k < NT; k++) m_xr[m_n & 7][k] = m_tap[k];
      m_n++;
   endtask

   task automatic step(input bit v, input int x, input int d, input bit ad,
                       input string tag, input bit zero_chk);
      int ye;
      int ee;
      @(negedge clk);
      chk(out_valid === pv[1], "R2", int'(out_valid), int'(pv[1]));
      if (pv[1]) begin
         chk(sxt(int'(out_y), WW) == py[1], pt[1], sxt(int'(out_y), WW), py[1]);
         chk(sxt(int'(out_e), WW) == pe[1], "R4", sxt(int'(out_e), WW), pe[1]);
         if (pz[1]) chk(out_y == '0, "R6", sxt(int'(out_y), WW), 0);
         last_y = sxt(int'(out_y), WW);
         last_e = sxt(int'(out_e), WW);
      end else begin
         chk(sxt(int'(out_y), WW) == last_y, "R9", sxt(int'(out_y), WW), last_y);
         chk(sxt(int'(out_e), WW) == last_e, "R9", sxt(int'(out_e), WW), last_e);
      end
      pv[1] = pv[0]; py[1] = py[0]; pe[1] = pe[0]; pt[1] = pt[0]; pz[1] = pz[0];
      if (v) begin
         model_step(x, d, ad, ye, ee);
         pv[0] = 1; py[0] = ye; pe[0] = ee; pt[0] = tag; pz[0] = zero_chk;
      end else begin
         pv[0] = 0;
      end
      in_valid = v;
      in_x     = x[XW-1:0];
      in_d     = d[WW-1:0];
      in_adapt = ad;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
      chk(out_y == '0, "R1", int'(out_y), 0);
      chk(out_e == '0, "R1", int'(out_e), 0);
      model_clear();
      rst = 1'b0;
   endtask

   initial begin
      model_clear();
      do_reset();
      // delay probe: y must stay zero until the first update reaches the filter side (R6, R7)
      for (int i = 0; i < 12; i++) step(1'b1, 100, 100, 1'b1, "R7", i <= ED + WD);
      // adapting sweep over every (x, d) byte pair, with idle gaps (R5, R9)
      for (int i = 0; i < 65536; i++) begin
         if ((i % 8) == 7) step(1'b0, 0, 0, 1'b1, "R9", 1'b0);
         step(1'b1, i & 255, ((i >> 8) ^ (i * 37)) & 255, 1'b1, "R5", 1'b0);
      end
      // frozen weights, sweep of the inner product (R3)
      for (int i = 0; i < 1024; i++)
         step(1'b1, (i * 53) & 255, (i * 11) & 255, 1'b0, "R3", 1'b0);
      // alternating adapt flag (R8)
      for (int i = 0; i < 512; i++)
         step(1'b1, (i * 29 + 7) & 255, (i * 91) & 255, 1'(i & 1), "R8", 1'b0);
      step(1'b0, 0, 0, 1'b0, "R9", 1'b0);
      step(1'b0, 0, 0, 1'b0, "R9", 1'b0);
      // reset in the middle of the run clears the trained weights (R1)
      do_reset();
      for (int i = 0; i < 8; i++) step(1'b1, 90, 60, 1'b1, "R1", i <= ED + WD);
      step(1'b0, 0, 0, 1'b0, "R9", 1'b0);
      step(1'b0, 0, 0, 1'b0, "R9", 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule